// File: doc/BRIEF.md
# Alarm Interrupt and Status Controller

This block watches two alarm channels on behalf of a real-time clock. Every cycle it compares the running time/date word with each channel's alarm compare word. When a channel is enabled and its comparison starts to match, the block sets that channel's sticky status bit and asserts an active-low interrupt. The block also keeps the sticky status bits that a set of low-supply detectors raises. It clears status bits when software asks for it. If auto-reset is enabled, it also clears them after a status read completes.

The interrupt line works in one of two modes. In pulse mode, every alarm trigger gives one low pulse of fixed length. The length is counted in millisecond ticks, which the block derives from its own clock. In level mode, the line stays low while either alarm status bit is set. The block also gates writes to the time registers. When an enabled time write completes, it starts the clock running and emits a one-cycle strobe that realigns the one-second tick.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, all status bits are 0, `irq_n` is 1, and `time_wr_ok`, `clk_run` and `sec_realign` are 0.
- R2: The control register bit positions are: bit 7 auto-reset enable, bit 6 time-write enable, bit 4 interrupt mode (1 = pulse, 0 = level), bit 1 alarm-1 enable and bit 0 alarm-0 enable. Bits 5, 3 and 2 always read 0.
- R3: When an enabled channel's compare starts to equal `time_now`, its status bit (bit 0 for alarm 0, bit 1 for alarm 1) reads 1 after the next clock edge. The bit stays set until it is cleared.
- R4: A channel whose enable bit is 0 does not set its status bit and does not affect `irq_n`.
- R5: A trigger fires only on the rising edge of a match. If a match persists after its status bit has been cleared, the bit is not set again.
- R6: In pulse mode, each trigger drives `irq_n` low from the edge after the match appears. It stays low for exactly PULSE_TICKS×TICK_DIV clock cycles, whatever the status bits hold.
- R7: In level mode, `irq_n` is low while status bit 0 or bit 1 is set. It returns high once both are clear.
- R8: A `stat_clr_we` strobe clears each status bit whose `stat_clr_mask` bit is 1 and leaves the other bits unchanged.
- R9: A pulse on `lowv_evt[i]` sets status bit 2+i, and the bit stays set.
- R10: If auto-reset is enabled, a `rd_done` strobe clears all five status bits. If auto-reset is disabled, `rd_done` has no effect.
- R11: A status bit set in the same cycle as a clearing `rd_done` or `stat_clr_we` strobe reads 1 afterwards.
- R12: `time_wr_ok` follows the time-write enable. When `time_wr_done` arrives with the enable set, `clk_run` reads 1 and `sec_realign` is high for exactly one cycle, both after the next edge. When the enable is clear, `time_wr_done` has no effect.
- R13: Writing the control register with the time-write enable 0 drops `clk_run` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read value |
| time_now | input | TIME_W | Running time/date word |
| alm0_cmp | input | TIME_W | Alarm 0 compare word |
| alm1_cmp | input | TIME_W | Alarm 1 compare word |
| lowv_evt | input | 3 | Low-supply detector set pulses |
| stat_clr_we | input | 1 | Explicit status clear strobe |
| stat_clr_mask | input | 5 | Status bits to clear |
| rd_done | input | 1 | Status read completed |
| time_wr_done | input | 1 | Time register write completed |
| status | output | 5 | Sticky status {lowv[2:0], alarm1, alarm0} |
| irq_n | output | 1 | Active-low interrupt |
| time_wr_ok | output | 1 | Time register writes permitted |
| clk_run | output | 1 | Clock counting |
| sec_realign | output | 1 | One-cycle one-second tick realign strobe |

## Verification
The assertions assume that every strobe input (`ctrl_we`, `stat_clr_we`, `rd_done`, `time_wr_done`, `lowv_evt`) is synchronous to `clk` and lasts one cycle. They also assume that `time_now` and the compare words change only between edges. The pulse-length bound assumes no new trigger arrives inside a pulse. A trigger that did would legally restart the window, so the checker resets its window on each trigger. The stimulus drives every input on the falling edge, holds each strobe for one cycle, and parks `time_now` on a non-matching value between scenarios. Each new match therefore begins as a clean rising edge.

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl #(
  parameter int TIME_W      = 48,
  parameter int TICK_DIV    = 32768,
  parameter int PULSE_TICKS = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_rdata,
  input  logic [TIME_W-1:0] time_now,
  input  logic [TIME_W-1:0] alm0_cmp,
  input  logic [TIME_W-1:0] alm1_cmp,
  input  logic [2:0]        lowv_evt,
  input  logic              stat_clr_we,
  input  logic [4:0]        stat_clr_mask,
  input  logic              rd_done,
  input  logic              time_wr_done,
  output logic [4:0]        status,
  output logic              irq_n,
  output logic              time_wr_ok,
  output logic              clk_run,
  output logic              sec_realign
);

  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam int PT_W  = $clog2(PULSE_TICKS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [PT_W-1:0]  PT_LAST  = PT_W'(PULSE_TICKS - 1);

  logic             arst_q, wen_q, im_q;
  logic [1:0]       ale_q;
  logic [1:0]       match, match_d, trig;
  logic [4:0]       stat_q, clr_v, set_v;
  logic             pulse_on;
  logic [DIV_W-1:0] div_q;
  logic [PT_W-1:0]  tick_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arst_q <= 1'b0;
      wen_q  <= 1'b0;
      im_q   <= 1'b0;
      ale_q  <= 2'b00;
    end else if (ctrl_we) begin
      arst_q <= ctrl_wdata[7];
      wen_q  <= ctrl_wdata[6];
      im_q   <= ctrl_wdata[4];
      ale_q  <= ctrl_wdata[1:0];
    end

  assign ctrl_rdata = {arst_q, wen_q, 1'b0, im_q, 2'b00, ale_q};

  assign match = {time_now == alm1_cmp, time_now == alm0_cmp};
  assign trig  = match & ~match_d & ale_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) match_d <= 2'b00;
    else        match_d <= match;

  assign set_v = {lowv_evt, trig};
  assign clr_v = (stat_clr_we ? stat_clr_mask : 5'b0) | {5{rd_done & arst_q}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_v) | set_v;

  assign status = stat_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pulse_on <= 1'b0;
      div_q    <= '0;
      tick_q   <= '0;
    end else if (|trig) begin
      pulse_on <= 1'b1;
      div_q    <= '0;
      tick_q   <= '0;
    end else if (pulse_on) begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (tick_q == PT_LAST) pulse_on <= 1'b0;
        else                   tick_q   <= tick_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end

  assign irq_n = ~(im_q ? pulse_on : |stat_q[1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_run     <= 1'b0;
      sec_realign <= 1'b0;
    end else begin
      sec_realign <= time_wr_done & wen_q;
      if (ctrl_we && !ctrl_wdata[6])  clk_run <= 1'b0;
      else if (time_wr_done && wen_q) clk_run <= 1'b1;
    end

  assign time_wr_ok = wen_q;

endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk #(
  parameter int TICK_DIV    = 32768,
  parameter int PULSE_TICKS = 250
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl_rdata,
  input logic       ctrl_we,
  input logic       stat_clr_we,
  input logic [4:0] stat_clr_mask,
  input logic       rd_done,
  input logic       time_wr_done,
  input logic [1:0] trig,
  input logic [4:0] status,
  input logic       irq_n,
  input logic       clk_run,
  input logic       sec_realign
);

  localparam int LIMIT = PULSE_TICKS * TICK_DIV;

  int low_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) low_cnt <= 0;
    else if ((|trig) || irq_n || !ctrl_rdata[4] || ctrl_we) low_cnt <= 0;
    else low_cnt <= low_cnt + 1;

  p_status_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] && !(stat_clr_we && stat_clr_mask[0]) && !(rd_done && ctrl_rdata[7])
    |=> status[0]);

  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1] && !ctrl_rdata[1] |=> !status[1]);

  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[4] && !irq_n |-> low_cnt < LIMIT);

  p_level_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[4] && $past(!ctrl_rdata[4]) && $rose(irq_n) |-> status[1:0] == 2'b00);

  p_autoclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && ctrl_rdata[7] && !ctrl_we && trig == 2'b00 |=> status[1:0] == 2'b00);

  p_realign_r12: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr_done && ctrl_rdata[6] && !ctrl_we |=> clk_run && sec_realign);

  p_realign_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !time_wr_done |=> !sec_realign);

endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(
  .TICK_DIV(TICK_DIV),
  .PULSE_TICKS(PULSE_TICKS)
) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .ctrl_rdata(ctrl_rdata),
  .ctrl_we(ctrl_we),
  .stat_clr_we(stat_clr_we),
  .stat_clr_mask(stat_clr_mask),
  .rd_done(rd_done),
  .time_wr_done(time_wr_done),
  .trig(trig),
  .status(status),
  .irq_n(irq_n),
  .clk_run(clk_run),
  .sec_realign(sec_realign)
);

// File: tb/alarm_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_tb_top;
  localparam int TW  = 48;
  localparam int DIV = 2;
  localparam int PT  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic [TW-1:0] time_now = 48'd1;
  logic [TW-1:0] alm0_cmp = 48'd100;
  logic [TW-1:0] alm1_cmp = 48'd200;
  logic [2:0] lowv_evt = '0;
  logic stat_clr_we = 1'b0;
  logic [4:0] stat_clr_mask = '0;
  logic rd_done = 1'b0;
  logic time_wr_done = 1'b0;
  logic [4:0] status;
  logic irq_n, time_wr_ok, clk_run, sec_realign;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  alarm_irq_ctrl #(.TIME_W(TW), .TICK_DIV(DIV), .PULSE_TICKS(PT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .time_now(time_now), .alm0_cmp(alm0_cmp),
    .alm1_cmp(alm1_cmp), .lowv_evt(lowv_evt), .stat_clr_we(stat_clr_we),
    .stat_clr_mask(stat_clr_mask), .rd_done(rd_done), .time_wr_done(time_wr_done),
    .status(status), .irq_n(irq_n), .time_wr_ok(time_wr_ok), .clk_run(clk_run),
    .sec_realign(sec_realign));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    step(1);
    ctrl_we = 1'b0;
  endtask

  task automatic clr(input logic [4:0] m);
    stat_clr_we = 1'b1; stat_clr_mask = m;
    step(1);
    stat_clr_we = 1'b0; stat_clr_mask = '0;
  endtask

  task automatic park;
    time_now = 48'd1;
    step(1);
    clr(5'h1f);
    wr_ctrl(8'h00);
    step(PT * DIV + 2);
  endtask

  task automatic t_reset;
    chk("R1 ctrl", ctrl_rdata, 8'h00);
    chk("R1 status", status, 5'h00);
    chk("R1 irq_n", irq_n, 1'b1);
    chk("R1 wr_ok/run/realign", {time_wr_ok, clk_run, sec_realign}, 3'b000);
  endtask

  task automatic t_layout;
    wr_ctrl(8'hFF);
    chk("R2 readback all ones", ctrl_rdata, 8'hD3);
    wr_ctrl(8'h2C);
    chk("R2 unused bits", ctrl_rdata, 8'h00);
    wr_ctrl(8'h00);
  endtask

  task automatic t_set_sticky;
    wr_ctrl(8'h03);
    time_now = alm0_cmp;
    step(1);
    chk("R3 alarm0 set", status, 5'h01);
    time_now = alm1_cmp;
    step(1);
    chk("R3 alarm1 set, alarm0 sticky", status, 5'h03);
    time_now = 48'd7;
    step(3);
    chk("R3 sticky after match ends", status, 5'h03);
    park();
  endtask

  task automatic t_disabled;
    wr_ctrl(8'h02);
    time_now = alm0_cmp;
    step(2);
    chk("R4 disabled alarm0 status", status, 5'h00);
    chk("R4 disabled alarm0 irq", irq_n, 1'b1);
    wr_ctrl(8'h12);
    time_now = 48'd1;
    step(1);
    time_now = alm0_cmp;
    step(2);
    chk("R4 disabled in pulse mode irq", irq_n, 1'b1);
    park();
  endtask

  task automatic t_no_retrigger;
    wr_ctrl(8'h01);
    time_now = alm0_cmp;
    step(1);
    chk("R5 first trigger", status[0], 1'b1);
    clr(5'h01);
    step(4);
    chk("R5 persisting match no reset", status[0], 1'b0);
    chk("R5 irq stays high", irq_n, 1'b1);
    park();
  endtask

  task automatic t_pulse;
    wr_ctrl(8'h11);
    time_now = alm0_cmp;
    step(1);
    chk("R6 pulse starts", irq_n, 1'b0);
    step(PT * DIV - 1);
    chk("R6 last low cycle", irq_n, 1'b0);
    step(1);
    chk("R6 pulse ended", irq_n, 1'b1);
    chk("R6 status independent", status[0], 1'b1);
    park();
  endtask

  task automatic t_level;
    wr_ctrl(8'h03);
    time_now = alm1_cmp;
    step(1);
    chk("R7 low on alarm1", irq_n, 1'b0);
    time_now = alm0_cmp;
    step(1);
    clr(5'h02);
    chk("R7 still low with alarm0", irq_n, 1'b0);
    chk("R8 only bit1 cleared", status, 5'h01);
    step(PT * DIV + 3);
    chk("R7 held low", irq_n, 1'b0);
    clr(5'h01);
    chk("R7 high when both clear", irq_n, 1'b1);
    park();
  endtask

  task automatic t_lowv_autoreset;
    wr_ctrl(8'h01);
    lowv_evt = 3'b101;
    step(1);
    lowv_evt = 3'b000;
    step(2);
    chk("R9 lowv bits", status, 5'h14);
    rd_done = 1'b1;
    step(1);
    rd_done = 1'b0;
    chk("R10 rd_done without auto-reset", status, 5'h14);
    wr_ctrl(8'h81);
    lowv_evt = 3'b010;
    step(1);
    lowv_evt = 3'b000;
    rd_done = 1'b1;
    step(1);
    rd_done = 1'b0;
    chk("R10 auto-reset clears", status, 5'h00);
    time_now = alm0_cmp;
    step(1);
    lowv_evt = 3'b001;
    rd_done = 1'b1;
    step(1);
    lowv_evt = 3'b000;
    rd_done = 1'b0;
    chk("R11 same-cycle set kept on read", status, 5'h04);
    stat_clr_we = 1'b1; stat_clr_mask = 5'h08;
    lowv_evt = 3'b010;
    step(1);
    stat_clr_we = 1'b0; stat_clr_mask = '0; lowv_evt = 3'b000;
    chk("R11 same-cycle set kept on clear", status, 5'h0C);
    park();
  endtask

  task automatic t_time_write;
    time_wr_done = 1'b1;
    step(1);
    time_wr_done = 1'b0;
    chk("R12 ignored without enable", {clk_run, sec_realign}, 2'b00);
    wr_ctrl(8'h40);
    chk("R12 wr_ok", time_wr_ok, 1'b1);
    time_wr_done = 1'b1;
    step(1);
    time_wr_done = 1'b0;
    chk("R12 run and realign", {clk_run, sec_realign}, 2'b11);
    step(1);
    chk("R12 realign one cycle", {clk_run, sec_realign}, 2'b10);
    wr_ctrl(8'h00);
    chk("R13 run stops", {clk_run, time_wr_ok}, 2'b00);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_layout();
    t_set_sticky();
    t_disabled();
    t_no_retrigger();
    t_pulse();
    t_level();
    t_lowv_autoreset();
    t_time_write();
    finish_run();
  end
endmodule